// File: doc/BRIEF.md
# Segmented Double-Buffered Converter Code Register

This block is the digital front end of a 12-bit converter. A 12-bit code is staged in two steps. First, three 4-bit staging segments are each loaded from their own slice of a shared 12-bit data bus. Each segment has its own write enable, and an active-low select gates all three enables. Second, a 12-bit output register copies all three segments at once while the transfer control is high. This lets a narrow bus assemble a full word piece by piece and then publish it in one atomic update.

Only the output register drives the outputs. The block presents three views of that register:

- the plain unipolar code;
- the offset-binary signed value, which is the code minus 2048;
- the bitwise complement, which matches the complementary current path.

Both stages are modelled as registers clocked by the system clock. The level-sensitive controls are sampled at each edge. When a segment write and a transfer happen in the same cycle, the fresh segment data flows through to the output register in that cycle.

Top module: `seg_dac_front`

## Requirements
- R1: An asynchronous active-low reset clears all staging segments and the output register. While reset is held, `code_out` is 0x000, `signed_out` is -2048 and `comp_out` is 0xFFF.
- R2: At a clock edge with `sel_n`=0, each segment whose enable bit is 1 loads its slice of `data_in`. Bit 2 of `seg_wr` loads bits 11:8, bit 1 loads bits 7:4 and bit 0 loads bits 3:0.
- R3: At a clock edge with `sel_n`=1, no segment changes, whatever the values of `seg_wr` and `data_in`.
- R4: A segment whose enable bit is 0 keeps its value while other segments are written.
- R5: At a clock edge with `xfer`=0, `code_out` keeps its value, whatever segment writes take place.
- R6: At a clock edge with `xfer`=1, the output register takes all three segments in parallel. The new value is visible on `code_out` after that edge.
- R7: If a segment write and `xfer`=1 occur at the same edge, the newly written slice reaches `code_out` after that same edge.
- R8: `signed_out` equals `code_out` minus 2048 as a two's-complement value, so 0x800 reads as 0, 0x000 as -2048 and 0xFFF as 2047.
- R9: `comp_out` is the bitwise complement of `code_out` at all times.
- R10: While `xfer` is held at 1 over several cycles, `code_out` follows every segment update one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_in | input | 12 | Data bus carrying all three segment slices |
| sel_n | input | 1 | Active-low select gating all segment writes |
| seg_wr | input | 3 | Per-segment write enables (bit 2 = most significant slice) |
| xfer | input | 1 | Transfer control; 1 passes the segments to the output register, 0 holds it |
| code_out | output | 12 | Output register contents (unipolar code) |
| signed_out | output | 12 | Offset-binary value, code minus 2048, two's complement |
| comp_out | output | 12 | Bitwise complement of the code |

## Verification
The bench builds the block with its default parameters: three segments of four bits each. With this configuration all 4096 codes can be assembled segment by segment and transferred, so the signed and complement mappings are confirmed for every code, not only at their end points. With only three enables, every enable combination can also be driven with and without select and transfer. This covers blocked writes, partial updates, same-edge flow-through and a held-open transfer.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;

    // Segment identifiers; the numeric value is the slice index on the bus.
    typedef enum logic [1:0] {
        SEG_LO  = 2'd0,
        SEG_MID = 2'd1,
        SEG_HI  = 2'd2
    } seg_id_e;

    // Offset-binary conversion: flipping the top bit equals subtracting half scale.
    function automatic logic [11:0] to_offset12(input logic [11:0] code);
        return {~code[11], code[10:0]};
    endfunction

endpackage

// File: rtl/seg_nibble_reg.sv
module seg_nibble_reg #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // The next value (write or hold) is chosen in the parent so that the same
    // value can also feed the transfer path.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/seg_xfer_reg.sv
module seg_xfer_reg #(
    parameter int unsigned WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pass,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (pass) begin
            q <= d;
        end
    end

endmodule

// File: rtl/seg_code_map.sv
module seg_code_map #(
    parameter int unsigned WIDTH = 12
) (
    input  logic [WIDTH-1:0]        code,
    output logic signed [WIDTH-1:0] offs,
    output logic [WIDTH-1:0]        comp
);

    // Subtracting 2^(WIDTH-1) modulo 2^WIDTH only inverts the top bit.
    always_comb begin
        offs = $signed({~code[WIDTH-1], code[WIDTH-2:0]});
        comp = ~code;
    end

endmodule

// File: rtl/seg_dac_front.sv
module seg_dac_front #(
    parameter int unsigned NIB_W   = 4,
    parameter int unsigned NUM_NIB = 3,
    localparam int unsigned CODE_W = NIB_W * NUM_NIB
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CODE_W-1:0]        data_in,
    input  logic                     sel_n,
    input  logic [NUM_NIB-1:0]       seg_wr,
    input  logic                     xfer,
    output logic [CODE_W-1:0]        code_out,
    output logic signed [CODE_W-1:0] signed_out,
    output logic [CODE_W-1:0]        comp_out
);

    logic [CODE_W-1:0] stage;
    logic [CODE_W-1:0] stage_next;
    logic [CODE_W-1:0] dac_q;

    // First stage: one independently written segment per bus slice.
    for (genvar g = 0; g < NUM_NIB; g++) begin : g_seg
        logic load;
        assign load = ~sel_n & seg_wr[g];
        assign stage_next[g*NIB_W +: NIB_W] =
            load ? data_in[g*NIB_W +: NIB_W] : stage[g*NIB_W +: NIB_W];

        seg_nibble_reg #(.WIDTH(NIB_W)) u_seg (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (stage_next[g*NIB_W +: NIB_W]),
            .q     (stage[g*NIB_W +: NIB_W])
        );
    end

    // Second stage: it takes the post-write segment values, which gives
    // same-edge flow-through.
    seg_xfer_reg #(.WIDTH(CODE_W)) u_xfer (
        .clk   (clk),
        .rst_n (rst_n),
        .pass  (xfer),
        .d     (stage_next),
        .q     (dac_q)
    );

    seg_code_map #(.WIDTH(CODE_W)) u_map (
        .code (dac_q),
        .offs (signed_out),
        .comp (comp_out)
    );

    assign code_out = dac_q;

endmodule

// File: rtl/seg_dac_front_sva.sv
module seg_dac_front_sva #(
    parameter int unsigned NIB_W   = 4,
    parameter int unsigned NUM_NIB = 3,
    localparam int unsigned CODE_W = NIB_W * NUM_NIB
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sel_n,
    input logic                     xfer,
    input logic [CODE_W-1:0]        stage,
    input logic [CODE_W-1:0]        code_out,
    input logic signed [CODE_W-1:0] signed_out,
    input logic [CODE_W-1:0]        comp_out
);

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (code_out == '0 && stage == '0));

    a_r3_sel_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> $stable(stage));

    a_r5_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(code_out));

    a_r6_parallel_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && sel_n) |=> (code_out == $past(stage)));

    a_r8_offset_value: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(signed_out) == int'({1'b0, code_out}) - (1 << (CODE_W-1))));

    a_r9_complement: assert property (@(posedge clk) disable iff (!rst_n)
        ((comp_out ^ code_out) == {CODE_W{1'b1}}));

endmodule

bind seg_dac_front seg_dac_front_sva #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_n      (sel_n),
    .xfer       (xfer),
    .stage      (stage),
    .code_out   (code_out),
    .signed_out (signed_out),
    .comp_out   (comp_out)
);

// File: tb/seg_dac_front_bench.sv
module seg_dac_front_bench;

    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] data_in = '0;
    logic          sel_n = 1'b1;
    logic [2:0]    seg_wr = '0;
    logic          xfer = 1'b0;
    logic [CW-1:0] code_out;
    logic signed [CW-1:0] signed_out;
    logic [CW-1:0] comp_out;

    int checks = 0;
    int errors = 0;
    logic [CW-1:0] m_stage = '0;
    logic [CW-1:0] m_dac = '0;

    always #10 clk = ~clk;

    seg_dac_front u_seg_dac_front (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .sel_n(sel_n),
        .seg_wr(seg_wr), .xfer(xfer), .code_out(code_out),
        .signed_out(signed_out), .comp_out(comp_out)
    );

    task automatic check_outputs(input string tag);
        int exp_s;
        exp_s = int'(m_dac) - 2048;
        checks++;
        if (code_out !== m_dac) begin
            errors++;
            $display("FAIL %s code_out actual %h expected %h", tag, code_out, m_dac);
        end
        checks++;
        if (int'(signed_out) != exp_s) begin
            errors++;
            $display("FAIL R8 (%s) signed_out actual %0d expected %0d", tag, signed_out, exp_s);
        end
        checks++;
        if (comp_out !== ~m_dac) begin
            errors++;
            $display("FAIL R9 (%s) comp_out actual %h expected %h", tag, comp_out, ~m_dac);
        end
    endtask

    // Drive at the falling edge; the rising edge applies it; check at the next falling edge.
    task automatic step(input logic s_n, input logic [2:0] en, input logic [CW-1:0] d,
                        input logic xf, input string tag);
        logic [CW-1:0] nxt;
        @(negedge clk);
        sel_n = s_n; seg_wr = en; data_in = d; xfer = xf;
        nxt = m_stage;
        for (int i = 0; i < 3; i++)
            if (!s_n && en[i]) nxt[i*4 +: 4] = d[i*4 +: 4];
        m_stage = nxt;
        if (xf) m_dac = nxt;
        @(negedge clk);
        check_outputs(tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        m_stage = '0; m_dac = '0;
        check_outputs("R1 reset");
        @(negedge clk) rst_n = 1'b1;

        // R2 slice placement, one segment at a time, then a transfer
        step(1'b0, 3'b100, 12'hA55, 1'b0, "R2 hi");
        step(1'b0, 3'b010, 12'h5B5, 1'b0, "R2 mid");
        step(1'b0, 3'b001, 12'h55C, 1'b0, "R2 lo");
        step(1'b1, 3'b000, 12'h000, 1'b1, "R2 ABC placement");

        // Sweep all codes: staged loads (R5) then one atomic transfer (R6, R8, R9)
        for (int c = 0; c < 4096; c++) begin
            step(1'b0, 3'b100, c[11:0], 1'b0, "R5 hold hi");
            step(1'b0, 3'b010, c[11:0], 1'b0, "R5 hold mid");
            step(1'b0, 3'b001, c[11:0], 1'b0, "R5 hold lo");
            step(1'b1, 3'b111, ~c[11:0], 1'b1, "R6 sweep xfer");
        end

        // R3: select high blocks all writes; a transfer exposes the unchanged segments
        step(1'b1, 3'b111, 12'h3C3, 1'b1, "R3 select blocks");
        step(1'b1, 3'b111, 12'h999, 1'b0, "R3 select blocks idle");
        step(1'b1, 3'b000, 12'h000, 1'b1, "R3 readback");

        // R4: partial writes keep the other segments
        step(1'b0, 3'b111, 12'h123, 1'b1, "R4 base");
        step(1'b0, 3'b010, 12'hFEF, 1'b0, "R4 mid only");
        step(1'b1, 3'b000, 12'h000, 1'b1, "R4 readback");
        step(1'b0, 3'b101, 12'h0F0, 1'b1, "R4 hi+lo with xfer");

        // R7: write and transfer on the same edge, every enable mix
        for (int e = 0; e < 8; e++)
            step(1'b0, e[2:0], 12'h5A5 ^ {3{e[3:0]}}, 1'b1, "R7 flow-through");

        // R10: transfer held open, output follows each write
        for (int k = 0; k < 12; k++)
            step(1'b0, 3'b001 << (k % 3), 12'h111 * k[11:0], 1'b1, "R10 held xfer");

        // R8 end points
        step(1'b0, 3'b111, 12'h800, 1'b1, "R8 midscale zero");
        step(1'b0, 3'b111, 12'h000, 1'b1, "R8 negative full scale");
        step(1'b0, 3'b111, 12'hFFF, 1'b1, "R8 positive full scale");

        // R1: asynchronous reset mid-run
        @(negedge clk) xfer = 1'b0; seg_wr = '0; sel_n = 1'b1;
        #5 rst_n = 1'b0;
        #2 m_stage = '0; m_dac = '0;
        check_outputs("R1 async reset");
        @(negedge clk) rst_n = 1'b1;
        step(1'b1, 3'b000, 12'h000, 1'b1, "R1 segments cleared");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule